// File: doc/BRIEF.md
# DDR3 Power-Up Reset Sequencer

This block takes an external DDR3 device out of reset before the memory controller starts to initialize it. On a start strobe it holds the memory reset pin low for a fixed interval. It then releases the pin and keeps clock enable low for a wait made of two parts: a programmable cycle count scaled by a per-family multiplier, and a fixed safety interval on top of it. When the wait ends it raises clock enable and pulses a done flag for one cycle.

Microsecond intervals are turned into cycle counts at elaboration, from the clock frequency given in MHz. Some silicon revisions sense the reset control bit inverted. A polarity input, sampled with the start strobe, chooses which level of the control bit means "reset asserted". The pin itself is always active low. The start, polarity and delay inputs are plain control pins: there is no data stream, so no valid/ready handshake and no back-pressure. A strobe the block cannot use is simply dropped.

Top module: `ddr3_rst_seq`

## Requirements
- R1: While `rst` is high, and afterwards until a start is accepted, the block is idle: `mem_reset_n`=0, `cke`=0, `done`=0 and `rst_ctl`=0.
- R2: A `start` sampled high at clock edge E0 in the idle or finished state holds `mem_reset_n` low until edge E0+RST_US*CLK_MHZ. `mem_reset_n` goes high after that edge.
- R3: After the reset release edge Er, `cke` stays low and rises after edge Er + `cke_dly`*CKE_MULT + SAFE_US*CLK_MHZ.
- R4: `done` is high for exactly the one cycle in which `cke` first goes high, and at no other time.
- R5: A `start` received while the hold or the wait is in progress is ignored. The running sequence keeps its timing and its polarity.
- R6: `rst_ctl` gives the level of the reset control bit. `inv_pol` is sampled with an accepted start. With `inv_pol`=0, `rst_ctl` is 0 during the hold and 1 after release. With `inv_pol`=1, it is 1 during the hold and 0 after release.
- R7: `rst` high at any point in a sequence returns the block to idle from the next cycle: `mem_reset_n`=0, `cke`=0, `done`=0.
- R8: A `start` accepted in the finished state, including in the cycle where `done` is high, begins a new sequence. `mem_reset_n` and `cke` go low after that edge, and the full timing of R2 and R3 repeats.
- R9: `cke` is never high while `mem_reset_n` is low.
- R10: `cke_dly` is sampled with an accepted start. Changes to it during a running sequence have no effect on the wait length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe for the power-up sequence |
| inv_pol | input | 1 | 1 selects inverted reset control sense |
| cke_dly | input | CKE_W | Programmable clock-enable delay, scaled by CKE_MULT |
| mem_reset_n | output | 1 | DDR3 reset pin, active low |
| rst_ctl | output | 1 | Reset control bit level under the selected polarity |
| cke | output | 1 | DDR3 clock enable |
| done | output | 1 | One-cycle pulse when clock enable rises |

## Verification
Two functions can fall in the same cycle: the completion pulse and the acceptance of a new start. The bench provokes this by raising `start` in exactly the cycle where `done` is high, with the opposite polarity and a zero delay. It then requires three things: `done` is still a single pulse, the pin falls after the next edge, and the new hold and wait repeat at the cycle counts the bench computed. A second clash is a start strobe in the middle of a hold together with a changed delay and polarity. It is judged by the scoreboard, which expects every pin transition at the cycles computed from the first start alone.

// File: rtl/ddr3rs_pkg.sv
package ddr3rs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2,
    ST_LIVE = 2'd3
  } seq_st_t;

  // microseconds to cycles at an integer MHz clock (product is already the ceiling)
  function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned mhz);
    return us * mhz;
  endfunction
endpackage

// File: rtl/ddr3rs_timer.sv
module ddr3rs_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ddr3rs_span.sv
module ddr3rs_span #(
  parameter int CKE_W    = 17,
  parameter int CKE_MULT = 3,
  parameter int SAFE_CYC = 200000,
  parameter int CNT_W    = 20
) (
  input  logic [CKE_W-1:0] dly,
  output logic [CNT_W-1:0] wait_load
);
  logic [CNT_W-1:0] ext;
  logic [CNT_W-1:0] scaled;

  assign ext = CNT_W'(dly);

  generate
    if (CKE_MULT == 2) begin : g_x2
      assign scaled = ext << 1;
    end else if (CKE_MULT == 3) begin : g_x3
      assign scaled = (ext << 1) + ext;
    end else begin : g_xn
      assign scaled = ext * CNT_W'(CKE_MULT);
    end
  endgenerate

  // total wait minus one, since the counter runs down to zero inclusive
  assign wait_load = scaled + CNT_W'(SAFE_CYC - 1);
endmodule

// File: rtl/ddr3_rst_seq.sv
module ddr3_rst_seq #(
  parameter int CLK_MHZ  = 400,
  parameter int RST_US   = 200,
  parameter int SAFE_US  = 500,
  parameter int CKE_W    = 17,
  parameter int CKE_MULT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             inv_pol,
  input  logic [CKE_W-1:0] cke_dly,
  output logic             mem_reset_n,
  output logic             rst_ctl,
  output logic             cke,
  output logic             done
);
  import ddr3rs_pkg::*;

  localparam int RST_CYC  = int'(us_to_cyc(RST_US, CLK_MHZ));
  localparam int SAFE_CYC = int'(us_to_cyc(SAFE_US, CLK_MHZ));
  localparam int MAX_WAIT = ((2 ** CKE_W) - 1) * CKE_MULT + SAFE_CYC;
  localparam int MAX_SPAN = (MAX_WAIT > RST_CYC) ? MAX_WAIT : RST_CYC;
  localparam int CNT_W    = $clog2(MAX_SPAN + 1);

  seq_st_t          st;
  logic             pol_q;
  logic [CKE_W-1:0] dly_q;
  logic             done_q;
  logic             accept;
  logic             zero;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic [CNT_W-1:0] wait_load;

  assign accept = start && (st == ST_IDLE || st == ST_LIVE);
  assign t_load = accept || (st == ST_HOLD && zero);
  assign t_val  = accept ? CNT_W'(RST_CYC - 1) : wait_load;

  ddr3rs_span #(
    .CKE_W   (CKE_W),
    .CKE_MULT(CKE_MULT),
    .SAFE_CYC(SAFE_CYC),
    .CNT_W   (CNT_W)
  ) u_span (
    .dly      (dly_q),
    .wait_load(wait_load)
  );

  ddr3rs_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .load_val(t_val),
    .zero    (zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      pol_q  <= 1'b0;
      dly_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE, ST_LIVE: begin
          if (start) begin
            st    <= ST_HOLD;
            pol_q <= inv_pol;
            dly_q <= cke_dly;
          end
        end
        ST_HOLD: begin
          if (zero) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (zero) begin
            st     <= ST_LIVE;
            done_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_reset_n = (st == ST_WAIT) || (st == ST_LIVE);
  assign rst_ctl     = mem_reset_n ^ pol_q;
  assign cke         = (st == ST_LIVE);
  assign done        = done_q;
endmodule

// File: rtl/ddr3rs_chk.sv
module ddr3rs_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic mem_reset_n,
  input logic cke,
  input logic done
);
  // R9
  cke_needs_release_chk: assert property (@(posedge clk) disable iff (rst)
    cke |-> mem_reset_n);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  done_with_cke_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cke && !$past(cke)));

  // R7
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!cke && !mem_reset_n && !done));

  // R3
  cke_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> $past(mem_reset_n));

  // R2
  pin_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_reset_n) |-> ($past(start) || $past(rst)));
endmodule

bind ddr3_rst_seq ddr3rs_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .mem_reset_n(mem_reset_n),
  .cke        (cke),
  .done       (done)
);

// File: tb/sim_ddr3_rst_seq.sv
module sim_ddr3_rst_seq;
  localparam int MHZ  = 2;
  localparam int MULT = 3;
  localparam int RC   = 200 * MHZ;
  localparam int SC   = 500 * MHZ;
  localparam int EV_FALL = 0;
  localparam int EV_REL  = 1;
  localparam int EV_CKE  = 2;

  typedef struct { int kind; int t; } ev_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        inv_pol = 1'b0;
  logic [16:0] cke_dly = '0;
  logic        mem_reset_n, rst_ctl, cke, done;

  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  ev_t q[$];

  ddr3_rst_seq #(.CLK_MHZ(MHZ), .CKE_MULT(MULT)) u0 (
    .clk(clk), .rst(rst), .start(start), .inv_pol(inv_pol), .cke_dly(cke_dly),
    .mem_reset_n(mem_reset_n), .rst_ctl(rst_ctl), .cke(cke), .done(done)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: caller is positioned just after a falling edge
  task automatic kick(input bit pol, input int dly);
    ev_t e;
    start = 1'b1; inv_pol = pol; cke_dly = 17'(dly);
    if (mem_reset_n) begin e.kind = EV_FALL; e.t = cyc + 1; q.push_back(e); end
    e.kind = EV_REL; e.t = cyc + 1 + RC;                  q.push_back(e);
    e.kind = EV_CKE; e.t = cyc + 1 + RC + dly * MULT + SC; q.push_back(e);
    @(negedge clk); #1 start = 1'b0;
  endtask

  task automatic do_reset();
    ev_t e;
    @(negedge clk); #1 rst = 1'b1;
    q.delete();
    if (mem_reset_n) begin e.kind = EV_FALL; e.t = cyc + 1; q.push_back(e); end
    @(negedge clk); #1 rst = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  // monitor / scoreboard
  initial begin
    bit pr, pc;
    ev_t e;
    pr = 1'b0; pc = 1'b0;
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (done && !(cke && !pc))
        chk(1'b0, "R4 done without cke rise", int'(done), 0);
      if (mem_reset_n != pr || (cke && !pc)) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2 unexpected transition", cyc, -1);
        end else begin
          e = q.pop_front();
          if (cke && !pc) begin
            chk(e.kind == EV_CKE, "R3 cke rise kind", EV_CKE, e.kind);
            chk(e.t == cyc, "R3 cke rise cycle", cyc, e.t);
            chk(done == 1'b1, "R4 done with cke", int'(done), 1);
            chk(mem_reset_n == 1'b1, "R9 cke with pin high", int'(mem_reset_n), 1);
          end else if (mem_reset_n) begin
            chk(e.kind == EV_REL, "R2 release kind", EV_REL, e.kind);
            chk(e.t == cyc, "R2 release cycle", cyc, e.t);
          end else begin
            chk(e.kind == EV_FALL, "R8 pin fall kind", EV_FALL, e.kind);
            chk(e.t == cyc, "R8 pin fall cycle", cyc, e.t);
          end
        end
      end
      pr = mem_reset_n; pc = cke;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({mem_reset_n, cke, done, rst_ctl} == 4'b0000, "R1 in reset", {mem_reset_n, cke, done, rst_ctl}, 0);
    #1 rst = 1'b0;
    repeat (20) @(negedge clk);
    chk({mem_reset_n, cke, done, rst_ctl} == 4'b0000, "R1 idle", {mem_reset_n, cke, done, rst_ctl}, 0);

    // normal polarity, delay 5; stray start, polarity and delay changes mid-run
    #1 kick(1'b0, 5);
    repeat (10) @(negedge clk);
    chk(rst_ctl == 1'b0, "R6 normal hold level", int'(rst_ctl), 0);
    #1 start = 1'b1; inv_pol = 1'b1; cke_dly = 17'd99;   // R5, R10
    @(negedge clk); #1 start = 1'b0;
    do @(negedge clk); while (!mem_reset_n);
    chk(rst_ctl == 1'b1, "R5 R6 polarity kept after release", int'(rst_ctl), 1);
    repeat (50) @(negedge clk);
    #1 cke_dly = 17'd400;                                // R10
    wait_done();

    // restart in the done cycle: inverted polarity, zero delay
    #1 kick(1'b1, 0);
    repeat (5) @(negedge clk);
    chk({mem_reset_n, cke} == 2'b00, "R8 restart holds reset", {mem_reset_n, cke}, 0);
    chk(rst_ctl == 1'b1, "R6 inverted hold level", int'(rst_ctl), 1);
    do @(negedge clk); while (!mem_reset_n);
    chk(rst_ctl == 1'b0, "R6 inverted release level", int'(rst_ctl), 0);
    wait_done();

    // abort mid-wait with reset
    repeat (4) @(negedge clk);
    #1 kick(1'b0, 7);
    do @(negedge clk); while (!mem_reset_n);
    repeat (200) @(negedge clk);
    do_reset();
    @(negedge clk);
    chk({mem_reset_n, cke, done} == 3'b000, "R7 abort to idle", {mem_reset_n, cke, done}, 0);
    repeat (RC + SC) @(negedge clk);
    chk({mem_reset_n, cke} == 2'b00, "R7 stays idle", {mem_reset_n, cke}, 0);

    // fresh run after abort
    #1 kick(1'b0, 2);
    wait_done();
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R3 all expected events seen", q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule